// File: doc/BRIEF.md
# System Clock Rate Controller with Automatic Low-Power Exit

This block turns a fast oscillator-rate clock into a system-rate clock enable. A small control register picks one of four normal ratios (1, 2, 4 or 8 oscillator cycles for each system cycle) or a fixed low-power ratio of 256. The output is a pulse one oscillator cycle wide that downstream logic uses as a clock enable. The oscillator clock itself is never gated.

While the low-power ratio is active, the normal ratio field is locked. If the wake-return enable is set, any active request on the wake vector drops the block out of low-power mode, and the ratio goes back to the stored normal setting. While a request stays active, low-power mode cannot be entered again. A stop-select bit holds the enable low without disturbing the stored ratio settings.

Top module: `sysclk_rate_ctl`

## Requirements
- R1: Register bits [1:0] (`rate_sel`) set the ratio when bit 2 is 0: 00 gives a pulse every cycle, 01 every 2 cycles, 10 every 4 cycles and 11 every 8 cycles.
- R2: When bit 2 (`lp_en`) is 1, the enable pulses once every 256 cycles whatever the value of bits [1:0].
- R3: While `lp_en` reads 1, a write leaves bits [1:0] at their old values. The other written bits still take effect.
- R4: When bit 3 (`wake_ret`) and `lp_en` are both 1 and any `wake_i` line is high at a clock edge, `lp_en` reads 0 after that edge and the ratio follows bits [1:0].
- R5: A write that sets `lp_en` together with `wake_ret`, made while any `wake_i` line is high, leaves `lp_en` at 0.
- R6: When `wake_ret` is 0, or `lp_en` is 0, the wake lines change no register bit.
- R7: Reset clears all five register bits, and the enable then pulses on every cycle.
- R8: While bit 4 (`halt`) is 1, `sys_ce_o` stays low and the stored ratio bits keep their values. Clearing the bit restores pulses at the stored ratio.
- R9: After a write that changes the effective ratio to N, the first pulse comes exactly N cycles after the write edge, never earlier.
- R10: For any ratio N greater than 1, each pulse lasts one cycle and is followed by exactly N-1 low cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 5 | Write data: [4] halt, [3] wake_ret, [2] lp_en, [1:0] rate_sel |
| rd_data_o | output | 5 | Current register contents, same layout as the write data |
| wake_i | input | 7 | Qualified wake requests, level sensitive |
| sys_ce_o | output | 1 | System clock enable pulse, one cycle wide |
| halt_o | output | 1 | Stop-mode select level, for power sequencing |

## Verification
The pulse spacing is measured at all four normal ratios and at the low-power ratio. Setting the low-power ratio with a nonzero normal field shows that bits [1:0] are ignored in that mode. The distance from a ratio-changing write to the first pulse is measured separately from the steady spacing, which shows whether the counter restarts or keeps its old phase. The wake lines are driven in three configurations: with wake-return on, with wake-return off, and with low-power mode off. Together these show that a wake request has an effect only when both bits are set. A seeded random sequence then mixes writes, wake vectors and halt, and compares the read-back value and the pulse spacing against a model of the register.

// File: rtl/sysclk_rate_pkg.sv
package sysclk_rate_pkg;

    localparam int RATE_W = 2;

    typedef struct packed {
        logic              halt;
        logic              wake_ret;
        logic              lp_en;
        logic [RATE_W-1:0] rate_sel;
    } rate_ctrl_t;

    localparam int CTRL_W = $bits(rate_ctrl_t);

    typedef struct packed {
        logic              lp_en;
        logic [RATE_W-1:0] rate_sel;
    } rate_cfg_t;

endpackage

// File: rtl/sysclk_rate_reg.sv
module sysclk_rate_reg
    import sysclk_rate_pkg::*;
#(
    parameter int WAKE_N = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic [WAKE_N-1:0] wake_i,
    output rate_ctrl_t        ctrl_o
);

    typedef struct packed {
        rate_ctrl_t ctrl;
    } reg_state_t;

    reg_state_t state_d, state_q;
    rate_ctrl_t wr_val;
    logic       wake_any;

    assign wr_val   = rate_ctrl_t'(wr_data_i);
    assign wake_any = |wake_i;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.ctrl.halt     = wr_val.halt;
            state_d.ctrl.wake_ret = wr_val.wake_ret;
            state_d.ctrl.lp_en    = wr_val.lp_en;
            if (!state_q.ctrl.lp_en) begin
                state_d.ctrl.rate_sel = wr_val.rate_sel;
            end
        end
        // wake return: exits low power and also blocks re-entry
        if (state_d.ctrl.wake_ret && state_d.ctrl.lp_en && wake_any) begin
            state_d.ctrl.lp_en = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o = state_q.ctrl;

    p_rate_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.ctrl.lp_en |=> $stable(state_q.ctrl.rate_sel));

    p_wake_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.ctrl.lp_en && state_q.ctrl.wake_ret && wake_any && !wr_en_i)
        |=> !state_q.ctrl.lp_en);

    p_no_reentry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_val.wake_ret && wake_any) |=> !state_q.ctrl.lp_en);

    p_wake_inert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !(state_q.ctrl.lp_en && state_q.ctrl.wake_ret))
        |=> $stable(state_q.ctrl));

endmodule

// File: rtl/sysclk_rate_tick.sv
module sysclk_rate_tick
    import sysclk_rate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  rate_cfg_t cfg_i,
    input  logic      halt_i,
    output logic      tick_o
);

    localparam int NORM_MAX = 1 << ((1 << RATE_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        rate_cfg_t        last_cfg;
    } tick_state_t;

    tick_state_t      state_d, state_q;
    logic [CNT_W-1:0] lim;
    logic             restart;

    initial begin
        if (NORM_MAX > (1 << CNT_W)) begin
            $error("CNT_W too small for the normal ratios");
        end
    end

    always_comb begin
        if (cfg_i.lp_en) begin
            lim = '1;
        end else begin
            lim = CNT_W'((32'd1 << cfg_i.rate_sel) - 32'd1);
        end
    end

    always_comb begin
        state_d          = state_q;
        restart          = halt_i || (cfg_i != state_q.last_cfg);
        tick_o           = !restart && (state_q.cnt == lim);
        state_d.last_cfg = cfg_i;
        if (restart || tick_o) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_i |-> !tick_o);

    p_no_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_i) |-> !tick_o);

    p_one_wide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && lim != '0) |=> !tick_o);

endmodule

// File: rtl/sysclk_rate_ctl.sv
module sysclk_rate_ctl
    import sysclk_rate_pkg::*;
#(
    parameter int WAKE_N = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic [WAKE_N-1:0] wake_i,
    output logic              sys_ce_o,
    output logic              halt_o
);

    rate_ctrl_t ctrl;
    rate_cfg_t  cfg;

    sysclk_rate_reg #(.WAKE_N(WAKE_N)) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .wake_i    (wake_i),
        .ctrl_o    (ctrl)
    );

    assign cfg.lp_en    = ctrl.lp_en;
    assign cfg.rate_sel = ctrl.rate_sel;

    sysclk_rate_tick #(.CNT_W(CNT_W)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cfg_i  (cfg),
        .halt_i (ctrl.halt),
        .tick_o (sys_ce_o)
    );

    assign rd_data_o = ctrl;
    assign halt_o    = ctrl.halt;

    p_reset_fast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> sys_ce_o);

endmodule

// File: tb/sysclk_rate_ctl_test.sv
`timescale 1ns/1ps
module sysclk_rate_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] rd_data;
    logic [6:0] wake = '0;
    logic       sys_ce;
    logic       halt;

    int checks = 0;
    int errors = 0;
    logic [4:0] model = '0;

    always #4 clk = ~clk;

    sysclk_rate_ctl uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .wake_i    (wake),
        .sys_ce_o  (sys_ce),
        .halt_o    (halt)
    );

    function automatic logic [4:0] next_reg(logic [4:0] cur, logic wr,
                                            logic [4:0] d, logic [6:0] w);
        logic [4:0] n = cur;
        if (wr) begin
            n[4:2] = d[4:2];
            if (!cur[2]) n[1:0] = d[1:0];
        end
        if (n[3] && n[2] && (|w)) n[2] = 1'b0;
        return n;
    endfunction

    function automatic int ratio_of(logic [4:0] r);
        if (r[4]) return 0;
        if (r[2]) return 256;
        return 1 << r[1:0];
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(logic wr, logic [4:0] d, logic [6:0] w, string req);
        logic [4:0] prev = model;
        int n_old, n_new, first, gap;
        @(negedge clk);
        wr_en = wr; wr_data = d; wake = w;
        @(posedge clk);
        model = next_reg(prev, wr, d, w);
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " readback"}, int'(rd_data), int'(model));
        check({req, " halt pin R8"}, int'(halt), int'(model[4]));
        n_old = ratio_of(prev);
        n_new = ratio_of(model);
        if (n_new == 0) begin
            first = 0;
            for (int i = 0; i < 20; i++) begin
                if (sys_ce) first++;
                @(negedge clk);
            end
            check({req, " R8 halted pulses"}, first, 0);
        end else begin
            first = 0;
            while (!sys_ce && first < 600) begin
                @(negedge clk);
                first++;
            end
            if (n_old != 0 && n_old != n_new)
                check({req, " R9 first pulse delay"}, first, n_new);
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!sys_ce && gap < 600);
            check({req, n_new > 1 ? " R10 pulse gap" : " R1 pulse gap"}, gap, n_new);
        end
        wake = '0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ce_cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ce_cnt = 0;
        for (int i = 0; i < 3; i++) begin
            if (sys_ce) ce_cnt++;
            @(negedge clk);
        end
        check("R7 reset readback", int'(rd_data), 0);
        check("R7 every-cycle pulses", ce_cnt, 3);

        // R1 all normal ratios
        apply(1'b1, 5'b00001, '0, "R1 div2");
        apply(1'b1, 5'b00010, '0, "R1 div4");
        apply(1'b1, 5'b00011, '0, "R1 div8");
        apply(1'b1, 5'b00000, '0, "R1 div1");
        // R2 low power ignores rate bits
        apply(1'b1, 5'b00110, '0, "R2 lp");
        // R3 rate bits locked
        apply(1'b1, 5'b00101, '0, "R3 locked write");
        // R6 wake ignored with wake_ret off
        apply(1'b0, 5'b00000, 7'h7f, "R6 wake_ret off");
        // R4 enable wake_ret, then wake exits
        apply(1'b1, 5'b01100, '0, "R4 arm");
        apply(1'b0, 5'b00000, 7'h10, "R4 wake exit");
        check("R4 lp cleared", int'(rd_data[2]), 0);
        // R5 re-entry blocked while wake held
        apply(1'b1, 5'b01101, 7'h01, "R5 blocked entry");
        check("R5 lp stays off", int'(rd_data[2]), 0);
        // R6 lp off: wakes inert
        apply(1'b0, 5'b00000, 7'h40, "R6 lp off");
        // R8 halt keeps ratio
        apply(1'b1, 5'b10011, '0, "R8 halt");
        check("R8 rate retained", int'(rd_data[1:0]), 3);
        apply(1'b1, 5'b00011, '0, "R8 resume");

        for (int k = 0; k < 30; k++) begin
            logic [4:0] d = 5'($urandom);
            logic [6:0] w = ($urandom % 3 == 0) ? 7'($urandom) : 7'h00;
            if ($urandom % 6 != 0) d[4] = 1'b0;
            apply(($urandom % 5) != 0, d, w, "random R1 R2 R3 R4 R5 R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule